// File: doc/BRIEF.md
# Predicated Variable-Width SIMD Adder

This execution block adds or subtracts two 64-bit source operands as a row of packed elements. The element width is chosen at run time from a small override code. The code is read relative to a default width, and that default follows the current machine width mode (64-bit or 32-bit). Because the default can be switched, the "half of default" code can reach 16-bit lanes in 32-bit mode, where it gives 32-bit lanes in 64-bit mode.

In vectorised mode each element acts as an independent register. Only the first VL elements are written. Every other bit of the destination comes back unchanged from the old destination value, which the block always reads in. In scalar mode only element 0 is computed. Its result is sign- or zero-extended across the full 64-bit destination. The result, a valid flag and an unsupported-width flag are registered, so the latency is one cycle.

Top module: `simd_pred_adder`

## Requirements
- R1: The element width is decoded from `width_sel`: 0 selects the default width, 1 selects default/2, 2 selects default*2, and 3 selects 8 bits. The default width is 64 when `mode32` is 0 and 32 when `mode32` is 1, so code 1 gives 16-bit lanes in 32-bit mode.
- R2: No carry or borrow crosses a lane boundary. When `sub` is 1, each lane computes a minus b modulo 2^width. When `sub` is 0, each lane computes a plus b modulo 2^width.
- R3: When `vec_en` is 1, lanes 0 to n-1 receive their results and every other destination bit equals `rd_old`. Here n is min(`vl`, lane count).
- R4: In vectorised mode, a `vl` of 0 writes `rd_old` back unchanged. A `vl` above the lane count is treated as the lane count.
- R5: In 32-bit mode, the vectorised lane count is 32/width for widths up to 32, so bits 32 to 63 are preserved. A 64-bit lane, reachable only through code 2 in 32-bit mode, counts as one lane.
- R6: When `vec_en` is 0, lane 0's result is extended over all 64 bits. The extension copies the lane's top bit if `sign_ext` is 1 and fills with zeros otherwise. `vl` has no effect in this mode.
- R7: Code 2 in 64-bit mode (a 128-bit width) is unsupported. It raises `bad_width` and gives `rd_new` = `rd_old`, whatever the other inputs are.
- R8: The outputs register one cycle after an input with `in_valid`=1. When `in_valid` is 0, `out_valid` drops the next cycle and `rd_new` and `bad_width` keep their values.
- R9: While `rst_n` is low, `out_valid`, `bad_width` and `rd_new` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operation request this cycle |
| sub | input | 1 | 1 = subtract, 0 = add |
| mode32 | input | 1 | 1 = 32-bit default width, 0 = 64-bit |
| width_sel | input | 2 | Element-width override code |
| vec_en | input | 1 | 1 = vectorised, 0 = scalar |
| vl | input | 4 | Vector length in elements |
| sign_ext | input | 1 | Scalar extension: 1 = sign, 0 = zero |
| src_a | input | 64 | First source register |
| src_b | input | 64 | Second source register |
| rd_old | input | 64 | Current destination value |
| out_valid | output | 1 | Result valid |
| bad_width | output | 1 | Requested width exceeds 64 bits |
| rd_new | output | 64 | Merged destination value |

## Verification
The hardest case to reach is a lane whose carry or borrow out must be dropped while a predicated-off neighbour still has to show the old destination bits. A purely random operand almost never sets up a full carry at exactly the lane edge where the predicate switches off. Directed vectors therefore place all-ones bytes and unit addends at each lane boundary, at several widths and VL values, including VL exactly at the lane count and one above it. A seeded random sweep across every mode, code and VL combination then checks merging and extension against a per-lane reference function.

// File: rtl/simd_pred_adder_pkg.sv
package simd_pred_adder_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned SLICE_W = 8;
  localparam int unsigned NSLICE  = DATA_W / SLICE_W;
  localparam int unsigned VL_W    = 4;
  localparam int unsigned LOG_W   = 3;

  typedef enum logic [1:0] {
    WSEL_DEFAULT = 2'd0,
    WSEL_HALF    = 2'd1,
    WSEL_DOUBLE  = 2'd2,
    WSEL_BYTE    = 2'd3
  } wsel_e;
endpackage

// File: rtl/simd_width_decode.sv
module simd_width_decode
  import simd_pred_adder_pkg::*;
(
  input  logic             mode32,
  input  logic [1:0]       width_sel,
  output logic [LOG_W-1:0] lane_log,
  output logic             unsupported,
  output logic [VL_W-1:0]  lane_limit
);
  logic [LOG_W-1:0] base_log;
  logic [LOG_W-1:0] region_log;

  always_comb begin
    base_log   = mode32 ? LOG_W'(5) : LOG_W'(6);
    region_log = base_log;
    case (wsel_e'(width_sel))
      WSEL_DEFAULT: lane_log = base_log;
      WSEL_HALF:    lane_log = base_log - LOG_W'(1);
      WSEL_DOUBLE:  lane_log = base_log + LOG_W'(1);
      default:      lane_log = LOG_W'(3);
    endcase
    unsupported = (lane_log == LOG_W'(7));
    if (lane_log >= region_log)
      lane_limit = VL_W'(1);
    else
      lane_limit = VL_W'(1) << (region_log - lane_log);
  end
endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_pred_adder_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [LOG_W-1:0]  lane_log,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] b_eff;
  logic [3:0]        seg_mask;

  assign b_eff = sub ? ~b : b;

  always_comb begin
    logic carry;
    logic cin;
    logic brk;
    seg_mask = (4'd1 << (lane_log - LOG_W'(3))) - 4'd1;
    carry    = 1'b0;
    sum      = '0;
    for (int i = 0; i < NSLICE; i++) begin
      brk = ((4'(i) & seg_mask) == 4'd0);
      cin = brk ? sub : carry;
      {carry, sum[i*SLICE_W +: SLICE_W]} =
        {1'b0, a[i*SLICE_W +: SLICE_W]} + {1'b0, b_eff[i*SLICE_W +: SLICE_W]}
        + {{SLICE_W{1'b0}}, cin};
    end
  end
endmodule

// File: rtl/simd_pred_merge.sv
module simd_pred_merge
  import simd_pred_adder_pkg::*;
(
  input  logic [DATA_W-1:0] sum,
  input  logic [DATA_W-1:0] rd_old,
  input  logic [LOG_W-1:0]  lane_log,
  input  logic [VL_W-1:0]   lane_limit,
  input  logic              unsupported,
  input  logic              vec_en,
  input  logic              sign_ext,
  input  logic [VL_W-1:0]   vl,
  output logic [DATA_W-1:0] result
);
  logic [VL_W-1:0]   vl_eff;
  logic [NSLICE-1:0] pred;
  logic [DATA_W-1:0] lane0_mask;
  logic              top_bit;
  logic [DATA_W-1:0] vec_res;
  logic [DATA_W-1:0] scl_res;

  assign vl_eff = (vl > lane_limit) ? lane_limit : vl;

  always_comb begin
    for (int i = 0; i < NSLICE; i++)
      pred[i] = (VL_W'(i >> (lane_log - LOG_W'(3))) < vl_eff);
  end

  always_comb begin
    for (int i = 0; i < NSLICE; i++)
      vec_res[i*SLICE_W +: SLICE_W] = pred[i] ? sum[i*SLICE_W +: SLICE_W]
                                              : rd_old[i*SLICE_W +: SLICE_W];
  end

  always_comb begin
    if (lane_log >= LOG_W'(6))
      lane0_mask = '1;
    else
      lane0_mask = (DATA_W'(1) << (DATA_W'(1) << lane_log)) - DATA_W'(1);
    top_bit = sum[(DATA_W'(1) << lane_log) - DATA_W'(1)];
    scl_res = (sum & lane0_mask) |
              ((sign_ext && top_bit) ? ~lane0_mask : '0);
  end

  always_comb begin
    if (unsupported)  result = rd_old;
    else if (vec_en)  result = vec_res;
    else              result = scl_res;
  end
endmodule

// File: rtl/simd_pred_adder.sv
module simd_pred_adder
  import simd_pred_adder_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              sub,
  input  logic              mode32,
  input  logic [1:0]        width_sel,
  input  logic              vec_en,
  input  logic [VL_W-1:0]   vl,
  input  logic              sign_ext,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] rd_old,
  output logic              out_valid,
  output logic              bad_width,
  output logic [DATA_W-1:0] rd_new
);
  logic [LOG_W-1:0]  lane_log;
  logic              unsupported;
  logic [VL_W-1:0]   lane_limit;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] merged;

  logic              valid_d;
  logic              bad_d;
  logic [DATA_W-1:0] rd_d;

  simd_width_decode u_dec (
    .mode32      (mode32),
    .width_sel   (width_sel),
    .lane_log    (lane_log),
    .unsupported (unsupported),
    .lane_limit  (lane_limit)
  );

  simd_seg_adder u_add (
    .a        (src_a),
    .b        (src_b),
    .sub      (sub),
    .lane_log (lane_log),
    .sum      (sum)
  );

  simd_pred_merge u_merge (
    .sum         (sum),
    .rd_old      (rd_old),
    .lane_log    (lane_log),
    .lane_limit  (lane_limit),
    .unsupported (unsupported),
    .vec_en      (vec_en),
    .sign_ext    (sign_ext),
    .vl          (vl),
    .result      (merged)
  );

  // next-state
  always_comb begin
    valid_d = in_valid;
    bad_d   = bad_width;
    rd_d    = rd_new;
    if (in_valid) begin
      bad_d = unsupported;
      rd_d  = merged;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bad_width <= 1'b0;
      rd_new    <= '0;
    end else begin
      out_valid <= valid_d;
      bad_width <= bad_d;
      rd_new    <= rd_d;
    end
  end

  // R8: a request shows up exactly one cycle later
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8: an idle cycle holds the result
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(rd_new) && $stable(bad_width)));
  // R7: an over-wide request leaves the destination alone
  a_r7_unsupported_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode32 && width_sel == 2'd2) |=>
      (bad_width && rd_new == $past(rd_old)));
  // R4: zero length in vectorised mode writes the old value back
  a_r4_vl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vec_en && vl == '0) |=> (rd_new == $past(rd_old)));
  // R5: 32-bit vectorised work below 64-bit lanes keeps the upper half
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vec_en && mode32 && width_sel != 2'd2) |=>
      (rd_new[DATA_W-1:DATA_W/2] == $past(rd_old[DATA_W-1:DATA_W/2])));
  // R6: zero extension in scalar byte mode clears the upper bits
  a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !vec_en && !sign_ext && width_sel == 2'd3) |=>
      (rd_new[DATA_W-1:SLICE_W] == '0));
endmodule

// File: tb/simd_pred_adder_tb.sv
module simd_pred_adder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, sub, mode32, vec_en, sign_ext;
  logic [1:0]  width_sel;
  logic [3:0]  vl;
  logic [63:0] src_a, src_b, rd_old;
  logic        out_valid, bad_width;
  logic [63:0] rd_new;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  simd_pred_adder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub(sub),
    .mode32(mode32), .width_sel(width_sel), .vec_en(vec_en), .vl(vl),
    .sign_ext(sign_ext), .src_a(src_a), .src_b(src_b), .rd_old(rd_old),
    .out_valid(out_valid), .bad_width(bad_width), .rd_new(rd_new)
  );

  function automatic int width_of(bit m32, bit [1:0] code);
    int d = m32 ? 32 : 64;
    case (code)
      2'd0: return d;
      2'd1: return d / 2;
      2'd2: return d * 2;
      default: return 8;
    endcase
  endfunction

  function automatic bit [64:0] model(bit [63:0] a, bit [63:0] b, bit s,
      bit m32, bit [1:0] code, bit v, int l, bit sx, bit [63:0] old);
    int w = width_of(m32, code);
    int region = m32 ? 32 : 64;
    int limit, eff, lanes;
    bit [63:0] m, r, la, lb, lr;
    if (w > 64) return {1'b1, old};
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    limit = (w >= region) ? 1 : region / w;
    lanes = 64 / w;
    eff = (l > limit) ? limit : l;
    r = old;
    if (!v) begin
      la = a & m; lb = b & m;
      lr = (s ? la - lb : la + lb) & m;
      if (sx && lr[w-1]) lr = lr | ~m;
      return {1'b0, lr};
    end
    for (int k = 0; k < lanes; k++) begin
      if (k < eff) begin
        la = (a >> (k*w)) & m; lb = (b >> (k*w)) & m;
        lr = (s ? la - lb : la + lb) & m;
        r = (r & ~(m << (k*w))) | (lr << (k*w));
      end
    end
    return {1'b0, r};
  endfunction

  task automatic check(string req, bit [63:0] act, bit [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, bit [63:0] a, bit [63:0] b, bit s, bit m32,
      bit [1:0] code, bit v, bit [3:0] l, bit sx, bit [63:0] old);
    bit [64:0] e;
    @(negedge clk);
    in_valid = 1'b1; src_a = a; src_b = b; sub = s; mode32 = m32;
    width_sel = code; vec_en = v; vl = l; sign_ext = sx; rd_old = old;
    e = model(a, b, s, m32, code, v, int'(l), sx, old);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check({req, " bad_width"}, {63'd0, bad_width}, {63'd0, e[64]});
    check({req, " rd_new"}, rd_new, e[63:0]);
  endtask

  initial begin
    bit [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; sub = 1'b0; mode32 = 1'b0; width_sel = 2'd0;
    vec_en = 1'b0; vl = 4'd0; sign_ext = 1'b0; src_a = '0; src_b = '0; rd_old = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset bad", {63'd0, bad_width}, 64'd0);
    check("R9 reset rd", rd_new, 64'd0);
    rst_n = 1'b1;

    // R3: byte lanes, VL=3, upper bytes kept
    apply("R3", 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 0, 0, 2'd3, 1, 4'd3, 0,
          64'hAAAA_BBBB_CCCC_DDDD);
    // R2: carries dropped at byte edges, add and subtract
    apply("R2 add", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 2'd3, 1, 4'd8, 0, 64'h0);
    apply("R2 sub", 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 1, 0, 2'd1, 1, 4'd2, 0,
          64'h5555_5555_5555_5555);
    // R1: code 1 in 32-bit mode gives 16-bit lanes
    apply("R1 half32", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0001_0001, 0, 1, 2'd1, 1, 4'd2, 0,
          64'h1234_5678_9ABC_DEF0);
    apply("R1 dbl32", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 1, 2'd2, 1, 4'd1, 0, 64'h77);
    // R4: VL zero and VL clamp
    apply("R4 vl0", 64'h1111, 64'h2222, 0, 0, 2'd3, 1, 4'd0, 0, 64'hDEAD_BEEF_0000_1111);
    apply("R4 clamp", 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 0, 0, 2'd1, 1, 4'd15, 0,
          64'h0123_4567_89AB_CDEF);
    // R5: 32-bit mode byte lanes, VL above 4 still leaves the upper half
    apply("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0202_0202_0202_0202, 0, 1, 2'd3, 1, 4'd8, 0,
          64'hCAFE_F00D_0000_0000);
    // R6: scalar sign and zero extension
    apply("R6 sign", 64'h7F, 64'h01, 0, 0, 2'd3, 0, 4'd5, 1, 64'h1234);
    apply("R6 zero", 64'h7F, 64'h01, 0, 0, 2'd3, 0, 4'd5, 0, 64'h1234);
    apply("R6 sign16", 64'h0, 64'h1, 1, 1, 2'd1, 0, 4'd0, 1, 64'hFFFF);
    // R7: unsupported width
    apply("R7", 64'h5, 64'h6, 0, 0, 2'd2, 1, 4'd1, 0, 64'hFEED_FACE_1234_5678);
    apply("R7 scalar", 64'h5, 64'h6, 1, 0, 2'd2, 0, 4'd1, 1, 64'h0BAD);

    // R8: idle cycle holds outputs
    apply("R8 pre", 64'h3, 64'h4, 0, 0, 2'd0, 1, 4'd1, 0, 64'h0);
    held = rd_new;
    @(negedge clk);
    src_a = 64'hFFFF; rd_old = 64'h9999; vec_en = 1'b0;
    @(negedge clk);
    check("R8 idle valid", {63'd0, out_valid}, 64'd0);
    check("R8 idle hold", rd_new, held);

    // seeded random sweep over all modes
    for (int i = 0; i < 3000; i++) begin
      bit [63:0] ra = {$urandom, $urandom};
      bit [63:0] rb = {$urandom, $urandom};
      bit [63:0] ro = {$urandom, $urandom};
      bit [31:0] ctl = $urandom;
      apply("R1-mix R2 R3 R6", ra, rb, ctl[0], ctl[1], ctl[3:2], ctl[4], ctl[8:5], ctl[9], ro);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule